// File: doc/BRIEF.md
# Boot Image Status Reader

This block runs a fixed three-step command sequence on a small memory-mapped register bus to learn which configuration image the device came up from. On a start pulse it writes a capture command to the configuration controller, then reads the controller's busy flag again and again until it drops, then reads the status word once and keeps a 4-bit image-state field taken from it. The result stays on registered outputs until the next successful run, so any other logic or an external reader can sample it at any time.

The bus side is a word-addressed master with a 3-bit address, separate read and write strobes, 32-bit data, a one-cycle read latency and an optional wait-request stall. The busy phase can last for well over a hundred cycles, so the block polls with no fixed delay. A bounded poll counter stops a run whose busy flag never clears and raises an error flag.

Top module: `boot_status_reader`

## Requirements
- R1: After synchronous reset, `done`, `err`, `av_read` and `av_write` are 0, and `img_state` and `raw_status` are all zeros.
- R2: A `start` pulse while idle causes exactly one write, to address 3'b010 with `av_writedata` equal to 32'h0000_0001 (capture command in bit 0).
- R3: After the capture write, the block reads address 3'b011 repeatedly and treats bit 0 of the returned word as busy; it issues no other read while that bit is 1.
- R4: The first poll that returns bit 0 equal to 0 is followed by exactly one read of address 3'b100; no other addresses are ever driven.
- R5: On completion `img_state` takes bits [16:13] of the address-3'b100 word (4'b1111 meaning nothing captured, 4'b0010 meaning image 0), `raw_status` takes the whole word, and `done` is 1 for exactly one cycle, the same cycle the two outputs change; they change at no other time.
- R6: While `av_read` or `av_write` is 1 and `av_waitrequest` is 1, the address, strobes and write data hold their values on the next cycle.
- R7: Read data is taken from `av_readdata` in the cycle after the read is accepted (strobe high with wait-request low), not in any other cycle.
- R8: If `POLL_LIMIT` consecutive polls all return busy, the run ends with `err` set to 1, no status read, no `done` pulse, and `img_state` and `raw_status` unchanged.
- R9: A `start` pulse arriving while a run is in progress has no effect: no extra capture write and no restart of the poll count.
- R10: `err` returns to 0 when a new run is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a run |
| done | output | 1 | One-cycle pulse when a new image state is stored |
| err | output | 1 | Set when the busy poll gives up; cleared on the next start |
| img_state | output | 4 | Stored image-state field |
| raw_status | output | 32 | Stored full status word |
| av_address | output | 3 | Word address of the current bus command |
| av_write | output | 1 | Write strobe |
| av_writedata | output | 32 | Write data |
| av_read | output | 1 | Read strobe |
| av_readdata | input | 32 | Read data, valid one cycle after an accepted read |
| av_waitrequest | input | 1 | Stall from the slave; commands hold while high |

## Verification
The bench builds the block with `POLL_LIMIT` set to 200 and the wait-request path enabled, keeping the other parameters at their defaults. A limit of 200 lets a run survive a busy phase of 150 polls and still puts both sides of the timeout boundary (199 busy polls succeed, 200 abort) within a short run. With the stall path built in, the bench can switch the slave's wait-request between always low and a pseudo-random pattern to test the hold rule and the read-latency sampling.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_TRIG = 2'd1,
    SQ_POLL = 2'd2,
    SQ_STAT = 2'd3
  } sq_state_t;

  typedef enum logic [1:0] {
    BP_IDLE = 2'd0,
    BP_CMD  = 2'd1,
    BP_RLAT = 2'd2
  } bp_state_t;

endpackage

// File: rtl/bsr_bus_port.sv
module bsr_bus_port #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter bit USE_WAITREQ = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic [ADDR_W-1:0] av_address,
  output logic              av_write,
  output logic [DATA_W-1:0] av_writedata,
  output logic              av_read,
  input  logic [DATA_W-1:0] av_readdata,
  input  logic              av_waitrequest
);
  import bsr_pkg::*;

  bp_state_t st;
  logic      stall;

  generate
    if (USE_WAITREQ) begin : g_wait
      assign stall = av_waitrequest;
    end else begin : g_nowait
      logic unused_wait;
      assign unused_wait = av_waitrequest;
      assign stall = 1'b0;
    end
  endgenerate

  assign req_ready = (st == BP_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= BP_IDLE;
      av_address   <= '0;
      av_write     <= 1'b0;
      av_read      <= 1'b0;
      av_writedata <= '0;
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        BP_IDLE: begin
          if (req_valid) begin
            av_address   <= req_addr;
            av_write     <= req_write;
            av_read      <= ~req_write;
            av_writedata <= req_write ? req_wdata : '0;
            st           <= BP_CMD;
          end
        end
        BP_CMD: begin
          if (!stall) begin
            av_write <= 1'b0;
            av_read  <= 1'b0;
            if (av_read) begin
              st <= BP_RLAT;
            end else begin
              rsp_valid <= 1'b1;
              st        <= BP_IDLE;
            end
          end
        end
        BP_RLAT: begin
          rsp_data  <= av_readdata;
          rsp_valid <= 1'b1;
          st        <= BP_IDLE;
        end
        default: st <= BP_IDLE;
      endcase
    end
  end

  // R6: a stalled command keeps every bus field steady
  assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (rst)
    ((av_read || av_write) && stall) |=>
      ($stable(av_address) && $stable(av_read) && $stable(av_write) && $stable(av_writedata)));

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !(av_read && av_write));

  // R7: a response follows only an accepted command
  assert_rsp_after_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (av_read && !stall) |=> (st == BP_RLAT) ##1 rsp_valid);

endmodule

// File: rtl/bsr_poll_timer.sv
module bsr_poll_timer #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_V = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign last = (cnt == LAST_V);

  // R8: the count of busy polls never passes the final slot
  assert_poll_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST_V);

endmodule

// File: rtl/bsr_seq.sv
module bsr_seq #(
  parameter int ADDR_W     = 3,
  parameter int DATA_W     = 32,
  parameter int TRIG_ADDR  = 2,
  parameter int BUSY_ADDR  = 3,
  parameter int STAT_ADDR  = 4,
  parameter int TRIG_BIT   = 0,
  parameter int BUSY_BIT   = 0,
  parameter int FIELD_LSB  = 13,
  parameter int FIELD_W    = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               req_ready,
  output logic               req_valid,
  output logic               req_write,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [DATA_W-1:0]  req_wdata,
  input  logic               rsp_valid,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic               tmr_clr,
  output logic               tmr_inc,
  input  logic               tmr_last,
  output logic               done,
  output logic               err,
  output logic [FIELD_W-1:0] img_state,
  output logic [DATA_W-1:0]  raw_status
);
  import bsr_pkg::*;

  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(TRIG_ADDR);
  localparam logic [ADDR_W-1:0] A_BUSY = ADDR_W'(BUSY_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);
  localparam int               F_MSB  = FIELD_LSB + FIELD_W - 1;

  sq_state_t st;
  logic      pend;
  logic      busy_bit;

  assign busy_bit  = rsp_data[BUSY_BIT];
  assign req_valid = (st != SQ_IDLE) && !pend && req_ready;
  assign req_write = (st == SQ_TRIG);
  assign req_wdata = DATA_W'(1) << TRIG_BIT;

  always_comb begin
    case (st)
      SQ_TRIG: req_addr = A_TRIG;
      SQ_POLL: req_addr = A_BUSY;
      default: req_addr = A_STAT;
    endcase
  end

  assign tmr_clr = (st == SQ_IDLE) && start;
  assign tmr_inc = (st == SQ_POLL) && rsp_valid && busy_bit && !tmr_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= SQ_IDLE;
      pend       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      img_state  <= '0;
      raw_status <= '0;
    end else begin
      done <= 1'b0;
      if (req_valid) begin
        pend <= 1'b1;
      end else if (rsp_valid) begin
        pend <= 1'b0;
      end
      case (st)
        SQ_IDLE: begin
          if (start) begin
            err <= 1'b0;
            st  <= SQ_TRIG;
          end
        end
        SQ_TRIG: begin
          if (rsp_valid) st <= SQ_POLL;
        end
        SQ_POLL: begin
          if (rsp_valid) begin
            if (!busy_bit) begin
              st <= SQ_STAT;
            end else if (tmr_last) begin
              err <= 1'b1;
              st  <= SQ_IDLE;
            end
          end
        end
        SQ_STAT: begin
          if (rsp_valid) begin
            img_state  <= rsp_data[F_MSB:FIELD_LSB];
            raw_status <= rsp_data;
            done       <= 1'b1;
            st         <= SQ_IDLE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  // R5: completion strobe lasts a single cycle
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5 / R8: stored result moves only together with done
  assert_img_hold_R8: assert property (@(posedge clk) disable iff (rst)
    ((img_state != $past(img_state)) || (raw_status != $past(raw_status))) |-> done);

  // R8: a timeout never coincides with a completion
  assert_err_no_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> !done);

  // R9: a capture write is only requested from the trigger step
  assert_single_trig_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |-> (st == SQ_TRIG));

endmodule

// File: rtl/boot_status_reader.sv
module boot_status_reader #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 32,
  parameter int POLL_LIMIT  = 1024,
  parameter bit USE_WAITREQ = 1'b1,
  parameter int TRIG_ADDR   = 2,
  parameter int BUSY_ADDR   = 3,
  parameter int STAT_ADDR   = 4,
  parameter int FIELD_LSB   = 13,
  parameter int FIELD_W     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  output logic               done,
  output logic               err,
  output logic [FIELD_W-1:0] img_state,
  output logic [DATA_W-1:0]  raw_status,
  output logic [ADDR_W-1:0]  av_address,
  output logic               av_write,
  output logic [DATA_W-1:0]  av_writedata,
  output logic               av_read,
  input  logic [DATA_W-1:0]  av_readdata,
  input  logic               av_waitrequest
);
  localparam logic [ADDR_W-1:0] A_TRIG = ADDR_W'(TRIG_ADDR);
  localparam logic [ADDR_W-1:0] A_BUSY = ADDR_W'(BUSY_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic              req_valid, req_write, req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_wdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              tmr_clr, tmr_inc, tmr_last;

  bsr_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .TRIG_ADDR(TRIG_ADDR), .BUSY_ADDR(BUSY_ADDR), .STAT_ADDR(STAT_ADDR),
    .TRIG_BIT(0), .BUSY_BIT(0),
    .FIELD_LSB(FIELD_LSB), .FIELD_W(FIELD_W)
  ) seq_i (
    .clk(clk), .rst(rst), .start(start),
    .req_ready(req_ready), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .tmr_clr(tmr_clr), .tmr_inc(tmr_inc), .tmr_last(tmr_last),
    .done(done), .err(err), .img_state(img_state), .raw_status(raw_status)
  );

  bsr_poll_timer #(.LIMIT(POLL_LIMIT)) tmr_i (
    .clk(clk), .rst(rst), .clr(tmr_clr), .inc(tmr_inc), .last(tmr_last)
  );

  bsr_bus_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .USE_WAITREQ(USE_WAITREQ)
  ) port_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .av_address(av_address), .av_write(av_write), .av_writedata(av_writedata),
    .av_read(av_read), .av_readdata(av_readdata), .av_waitrequest(av_waitrequest)
  );

  // R2: writes go only to the capture register with the command bit set
  assert_trig_write_R2: assert property (@(posedge clk) disable iff (rst)
    av_write |-> ((av_address == A_TRIG) && (av_writedata == DATA_W'(1))));

  // R4: reads target only the busy or the status register
  assert_read_addr_R4: assert property (@(posedge clk) disable iff (rst)
    av_read |-> ((av_address == A_BUSY) || (av_address == A_STAT)));

endmodule

// File: tb/boot_status_reader_tb_top.sv
module boot_status_reader_tb_top;
  localparam int LIM = 200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        done, err;
  logic [3:0]  img_state;
  logic [31:0] raw_status;
  logic [2:0]  av_address;
  logic        av_write, av_read;
  logic [31:0] av_writedata;
  logic [31:0] av_readdata = 32'hDEAD_BEEF;
  logic        av_waitrequest = 1'b0;

  always #4 clk = ~clk;

  boot_status_reader #(.POLL_LIMIT(LIM), .USE_WAITREQ(1'b1)) dut_i (
    .clk(clk), .rst(rst), .start(start), .done(done), .err(err),
    .img_state(img_state), .raw_status(raw_status),
    .av_address(av_address), .av_write(av_write), .av_writedata(av_writedata),
    .av_read(av_read), .av_readdata(av_readdata), .av_waitrequest(av_waitrequest)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural slave
  int          busy_cfg = 0;
  int          busy_left = 0;
  logic [31:0] stat_word = '0;
  bit          wr_mode = 0;
  logic [7:0]  lfsr = 8'hA5;
  int          n_wr = 0, n_poll = 0, n_stat = 0, n_bad = 0, n_hold = 0;
  logic [2:0]  last_wr_addr = '0;
  logic [31:0] last_wr_data = '0;
  logic        p_cmd = 0;
  logic [2:0]  p_addr = '0;
  logic        p_rd = 0, p_wr = 0;
  logic [31:0] p_wd = '0;

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    av_waitrequest <= wr_mode ? lfsr[0] : 1'b0;
    av_readdata <= 32'hDEAD_BEEF;
    if (p_cmd && (av_address != p_addr || av_read != p_rd || av_write != p_wr ||
                  av_writedata != p_wd))
      n_hold <= n_hold + 1;
    p_cmd  <= (av_read || av_write) && av_waitrequest;
    p_addr <= av_address; p_rd <= av_read; p_wr <= av_write; p_wd <= av_writedata;
    if (!rst && (av_read || av_write) && !av_waitrequest) begin
      if (av_write) begin
        n_wr <= n_wr + 1;
        last_wr_addr <= av_address;
        last_wr_data <= av_writedata;
        if (av_address == 3'b010 && av_writedata[0]) busy_left <= busy_cfg;
      end else if (av_address == 3'b011) begin
        n_poll <= n_poll + 1;
        av_readdata <= {31'b0, busy_left != 0};
        if (busy_left != 0) busy_left <= busy_left - 1;
      end else if (av_address == 3'b100) begin
        n_stat <= n_stat + 1;
        av_readdata <= stat_word;
      end else begin
        n_bad <= n_bad + 1;
      end
    end
  end

  // scoreboard
  typedef struct { logic [3:0] img; logic [31:0] raw; bit to; } exp_t;
  exp_t q[$];
  int   events = 0;
  logic err_q = 0;
  logic done_q = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (done_q && done) check(0, "R5", "done longer than one cycle", 1, 0);
      if (done || (err && !err_q)) begin
        if (q.size() == 0) begin
          check(0, "R5", "unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(err == e.to, "R8", "timeout flag", err, e.to);
          check(img_state == e.img, e.to ? "R8" : "R5", "img_state", img_state, e.img);
          check(raw_status == e.raw, e.to ? "R8" : "R5", "raw_status", raw_status, e.raw);
        end
        events++;
      end
      err_q  <= err;
      done_q <= done;
    end
  end

  logic [3:0]  m_img = '0;
  logic [31:0] m_raw = '0;

  task automatic run_seq(input int busy_n, input logic [31:0] word, input bit restart,
                         input string tag);
    exp_t e;
    int   w0, p0, s0, ev0, exp_polls;
    bit   to;
    to = (busy_n >= LIM);
    if (!to) begin m_img = word[16:13]; m_raw = word; end
    e.img = m_img; e.raw = m_raw; e.to = to;
    q.push_back(e);
    busy_cfg = busy_n; stat_word = word;
    w0 = n_wr; p0 = n_poll; s0 = n_stat; ev0 = events;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(err == 1'b0, "R10", {tag, " err cleared on start"}, err, 0);
    if (restart) begin
      repeat (20) @(negedge clk);
      start = 1'b1; @(negedge clk); start = 1'b0;
    end
    for (int i = 0; i < 20000 && events == ev0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    exp_polls = to ? LIM : busy_n + 1;
    check(n_wr - w0 == 1, restart ? "R9" : "R2", {tag, " capture writes"}, n_wr - w0, 1);
    check(n_poll - p0 == exp_polls, restart ? "R9" : "R3", {tag, " busy polls"},
          n_poll - p0, exp_polls);
    check(n_stat - s0 == (to ? 0 : 1), to ? "R8" : "R4", {tag, " status reads"},
          n_stat - s0, to ? 0 : 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!done && !err && !av_read && !av_write, "R1", "control outputs after reset",
          {done, err, av_read, av_write}, 0);
    check(img_state == 0 && raw_status == 0, "R1", "result outputs after reset",
          raw_status, 0);

    run_seq(0, 32'h1234_4ABC, 0, "image0");
    check(last_wr_addr == 3'b010 && last_wr_data == 32'h1, "R2", "write address/data",
          {last_wr_addr, last_wr_data}, {3'b010, 32'h1});
    run_seq(150, 32'h0001_FFFF, 0, "long busy");
    wr_mode = 1;
    run_seq(5, 32'hA5A5_4000, 0, "stalled bus");
    run_seq(LIM + 100, 32'hFFFF_FFFF, 0, "timeout");
    check(err == 1'b1, "R8", "err held after timeout", err, 1);
    run_seq(3, 32'h0000_2000, 0, "after timeout");
    run_seq(20, 32'h7777_E000, 1, "restart ignored");
    wr_mode = 0;
    run_seq(LIM - 1, 32'h0001_6000, 0, "limit-1");
    run_seq(LIM, 32'h0000_0000, 0, "limit");
    check(n_hold == 0, "R6", "stalled command changed", n_hold, 0);
    check(n_bad == 0, "R4", "stray address accesses", n_bad, 0);
    check(q.size() == 0, "R7", "pending expected results", q.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule